// File: doc/BRIEF.md
# Sub-word Multiply-Add Unit

This unit takes two 32-bit source words and pulls a narrow operand out of each. The operand is either one byte, picked by a byte index, or one 16-bit half. The two operands are multiplied, a full 32-bit addend is added, and the sum can then be shifted right by a fixed 7 or 15 places. It is meant for media-style integer work, where packed 8- and 16-bit samples are scaled and biased inside one wider word.

The second factor can also come from a 16-bit immediate instead of a register. One registered stage holds the result, a valid strobe, an unsupported-encoding indicator and a pair of zero/sign flags. The flags change only when the caller asks for them to be updated. Selecting a full-word or reserved half type is not carried out: that operand is treated as zero and the unsupported indicator is raised.

Top module: `vmad_unit`

## Requirements
- R1: With the half-mode bit clear, an operand is the byte of its source word at bit offset 8×index, where the index runs from 0 to 3.
- R2: With the half-mode bit set, kind code 0 selects source bits 15:0 and kind code 1 selects source bits 31:16.
- R3: For a register operand in half mode, kind code 2 (full word) and kind code 3 (reserved) give an operand of zero and set `unsupported` for that result. Otherwise `unsupported` is cleared.
- R4: When `b_is_reg` is low, operand B is `imm_b`. It is sign-extended if `b_signed` is set and zero-extended if not. The B half-mode, kind and index inputs then have no effect, and that includes `unsupported`.
- R5: An extracted byte or half is sign-extended to 32 bits when the operand's signed bit is set, and zero-extended when it is clear.
- R6: Before the shift, the value is A×B + C, kept to its low 32 bits.
- R7: Shift code 0 and code 3 apply no shift, code 1 shifts right by 7 and code 2 shifts right by 15. The shift is arithmetic when either operand is signed and logical when neither is.
- R8: `flag_zero` and `flag_sign` take the final result's zero test and bit 31 only on an accepted operation with `cc_en` high. In every other cycle they hold their value.
- R9: An operation accepted with `in_valid` appears on `result` and `unsupported`, with `out_valid` high, in the next cycle. In a cycle without `in_valid`, `out_valid` is low and `result` and `unsupported` hold.
- R10: While `rst_n` is low, `out_valid`, `result`, `flag_zero`, `flag_sign` and `unsupported` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| src_a | input | 32 | Source word for operand A |
| src_b | input | 32 | Source word for operand B when taken from a register |
| src_c | input | 32 | 32-bit addend |
| imm_b | input | 16 | Immediate for operand B |
| b_is_reg | input | 1 | 1: B from src_b, 0: B from imm_b |
| a_signed | input | 1 | Operand A is signed |
| a_half_mode | input | 1 | A: 1 selects a half, 0 selects a byte |
| a_kind | input | 2 | A half kind: 0 low, 1 high, 2 full, 3 reserved |
| a_byte_idx | input | 2 | A byte index |
| b_signed | input | 1 | Operand B is signed |
| b_half_mode | input | 1 | B: 1 selects a half, 0 selects a byte |
| b_kind | input | 2 | B half kind, same codes as A |
| b_byte_idx | input | 2 | B byte index |
| shift_sel | input | 2 | 0 none, 1 right 7, 2 right 15, 3 none |
| cc_en | input | 1 | Update the zero/sign flags |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Registered result |
| flag_zero | output | 1 | Result was zero |
| flag_sign | output | 1 | Result bit 31 |
| unsupported | output | 1 | Unsupported operand kind was used |

## Verification
Every byte index and both halves are driven with sources whose bytes all differ. This exposes a swapped index or a swapped half, and high-bit samples with the signed bit on and off separate sign extension from zero extension. Immediates with bit 15 set are run both signed and unsigned. A reserved B kind is paired with an immediate to show that the register-only decode does not leak through. Negative and positive sums go through each shift code with mixed signedness, which separates arithmetic from logical shifts and code 3 from code 0. Cycles with `cc_en` low, and idle cycles, show the flags and the result holding. A long random run then covers the arithmetic wrap.

// File: rtl/vmad_pkg.sv
package vmad_pkg;

    typedef enum logic [1:0] {
        KIND_LO   = 2'd0,
        KIND_HI   = 2'd1,
        KIND_FULL = 2'd2,
        KIND_RSVD = 2'd3
    } half_kind_e;

    typedef enum logic [1:0] {
        SHR_NONE  = 2'd0,
        SHR_SMALL = 2'd1,
        SHR_LARGE = 2'd2,
        SHR_SPARE = 2'd3
    } shr_mode_e;

endpackage

// File: rtl/vmad_operand_sel.sv
module vmad_operand_sel
    import vmad_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int N_BYTE = DATA_W / BYTE_W,
    localparam int SEL_W  = $clog2(N_BYTE)
) (
    input  logic [DATA_W-1:0] word,
    input  logic              half_mode,
    input  logic [1:0]        kind,
    input  logic [SEL_W-1:0]  byte_idx,
    input  logic              is_signed,
    output logic [DATA_W-1:0] operand,
    output logic              unsup
);

    logic [BYTE_W-1:0] lanes [N_BYTE];

    for (genvar g = 0; g < N_BYTE; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    logic [BYTE_W-1:0] byte_sel_d;
    logic [HALF_W-1:0] half_sel_d;

    always_comb begin
        byte_sel_d = lanes[byte_idx];
        half_sel_d = '0;
        unsup      = 1'b0;
        operand    = '0;
        if (!half_mode) begin
            operand = {{(DATA_W-BYTE_W){is_signed & byte_sel_d[BYTE_W-1]}}, byte_sel_d};
        end else begin
            case (half_kind_e'(kind))
                KIND_LO: half_sel_d = word[HALF_W-1:0];
                KIND_HI: half_sel_d = word[DATA_W-1:HALF_W];
                default: unsup      = 1'b1;
            endcase
            if (!unsup) begin
                operand = {{(DATA_W-HALF_W){is_signed & half_sel_d[HALF_W-1]}}, half_sel_d};
            end
        end
    end

endmodule

// File: rtl/vmad_datapath.sv
module vmad_datapath
    import vmad_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IMM_W       = 16,
    parameter int SHIFT_SMALL = 7,
    parameter int SHIFT_LARGE = 15
) (
    input  logic [DATA_W-1:0] a_op,
    input  logic [DATA_W-1:0] b_reg_op,
    input  logic [DATA_W-1:0] addend,
    input  logic [IMM_W-1:0]  imm,
    input  logic              b_from_reg,
    input  logic              a_signed,
    input  logic              b_signed,
    input  logic [1:0]        shift_sel,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0] b_imm_d;
    logic [DATA_W-1:0] b_op_d;
    logic [DATA_W-1:0] sum_d;
    logic              res_signed_d;

    always_comb begin
        b_imm_d      = {{(DATA_W-IMM_W){b_signed & imm[IMM_W-1]}}, imm};
        b_op_d       = b_from_reg ? b_reg_op : b_imm_d;
        // low half of the product is the same for signed and unsigned factors
        sum_d        = a_op * b_op_d + addend;
        res_signed_d = a_signed | b_signed;
        case (shr_mode_e'(shift_sel))
            SHR_SMALL: value = res_signed_d ? DATA_W'($signed(sum_d) >>> SHIFT_SMALL)
                                            : (sum_d >> SHIFT_SMALL);
            SHR_LARGE: value = res_signed_d ? DATA_W'($signed(sum_d) >>> SHIFT_LARGE)
                                            : (sum_d >> SHIFT_LARGE);
            default:   value = sum_d;
        endcase
    end

endmodule

// File: rtl/vmad_unit.sv
module vmad_unit
    import vmad_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IMM_W       = 16,
    parameter int BYTE_W      = 8,
    parameter int SHIFT_SMALL = 7,
    parameter int SHIFT_LARGE = 15,
    localparam int SEL_W      = $clog2(DATA_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    input  logic [IMM_W-1:0]  imm_b,
    input  logic              b_is_reg,
    input  logic              a_signed,
    input  logic              a_half_mode,
    input  logic [1:0]        a_kind,
    input  logic [SEL_W-1:0]  a_byte_idx,
    input  logic              b_signed,
    input  logic              b_half_mode,
    input  logic [1:0]        b_kind,
    input  logic [SEL_W-1:0]  b_byte_idx,
    input  logic [1:0]        shift_sel,
    input  logic              cc_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              unsupported
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] value;
        logic              zf;
        logic              sf;
        logic              unsup;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] a_op, b_op, dp_value;
    logic              a_unsup, b_unsup;

    vmad_operand_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_sel_a (
        .word      (src_a),
        .half_mode (a_half_mode),
        .kind      (a_kind),
        .byte_idx  (a_byte_idx),
        .is_signed (a_signed),
        .operand   (a_op),
        .unsup     (a_unsup)
    );

    vmad_operand_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_sel_b (
        .word      (src_b),
        .half_mode (b_half_mode),
        .kind      (b_kind),
        .byte_idx  (b_byte_idx),
        .is_signed (b_signed),
        .operand   (b_op),
        .unsup     (b_unsup)
    );

    vmad_datapath #(
        .DATA_W      (DATA_W),
        .IMM_W       (IMM_W),
        .SHIFT_SMALL (SHIFT_SMALL),
        .SHIFT_LARGE (SHIFT_LARGE)
    ) i_datapath (
        .a_op       (a_op),
        .b_reg_op   (b_op),
        .addend     (src_c),
        .imm        (imm_b),
        .b_from_reg (b_is_reg),
        .a_signed   (a_signed),
        .b_signed   (b_signed),
        .shift_sel  (shift_sel),
        .value      (dp_value)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.value = dp_value;
            st_d.unsup = a_unsup | (b_is_reg & b_unsup);
            if (cc_en) begin
                st_d.zf = (dp_value == '0);
                st_d.sf = dp_value[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign result      = st_q.value;
    assign flag_zero   = st_q.zf;
    assign flag_sign   = st_q.sf;
    assign unsupported = st_q.unsup;

    // timing of the result strobe
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(unsupported)));

    // flag update gating
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && cc_en) |=> ($stable(flag_zero) && $stable(flag_sign)));
    assert_flag_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cc_en) |=> (flag_zero == (result == '0) && flag_sign == result[DATA_W-1]));

    // reserved and full-word kinds on a register operand
    assert_unsup_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_half_mode && a_kind[1]) |=> unsupported);
    assert_imm_ignores_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !b_is_reg && !a_unsup) |=> !unsupported);

    // a 15-place shift leaves the top bits as pure sign or zero fill
    assert_shift_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_sel == 2'd2 && !(a_signed || b_signed))
        |=> (result[DATA_W-1 -: SHIFT_LARGE] == '0));
    assert_shift_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_sel == 2'd2 && (a_signed || b_signed))
        |=> ($countones(result[DATA_W-1 -: SHIFT_LARGE+1]) == 0
             || $countones(result[DATA_W-1 -: SHIFT_LARGE+1]) == SHIFT_LARGE+1));

endmodule

// File: tb/test_vmad_unit.sv
module test_vmad_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] src_a, src_b, src_c;
    logic [15:0] imm_b;
    logic        b_is_reg, a_signed, a_half_mode, b_signed, b_half_mode, cc_en;
    logic [1:0]  a_kind, a_byte_idx, b_kind, b_byte_idx, shift_sel;
    logic        out_valid, flag_zero, flag_sign, unsupported;
    logic [31:0] result;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    logic        e_valid, e_zf, e_sf, e_unsup;
    logic [31:0] e_result;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmad_unit i_vmad_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm_b(imm_b),
        .b_is_reg(b_is_reg), .a_signed(a_signed), .a_half_mode(a_half_mode),
        .a_kind(a_kind), .a_byte_idx(a_byte_idx), .b_signed(b_signed),
        .b_half_mode(b_half_mode), .b_kind(b_kind), .b_byte_idx(b_byte_idx),
        .shift_sel(shift_sel), .cc_en(cc_en), .out_valid(out_valid),
        .result(result), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .unsupported(unsupported)
    );

    // {unsupported, value}
    function automatic logic [32:0] ref_ext(logic [31:0] w, logic half, logic [1:0] k,
                                            logic [1:0] idx, logic sgn);
        longint v;
        if (!half) begin
            v = (w >> (idx * 8)) & 32'hFF;
            if (sgn && v >= 128) v = v - 256;
        end else if (k == 2'd0 || k == 2'd1) begin
            v = (k == 2'd0) ? (w & 32'hFFFF) : (w >> 16);
            if (sgn && v >= 32768) v = v - 65536;
        end else begin
            return {1'b1, 32'd0};
        end
        return {1'b0, v[31:0]};
    endfunction

    task automatic compare(input string tag);
        compared++;
        if (out_valid !== e_valid || result !== e_result || flag_zero !== e_zf ||
            flag_sign !== e_sf || unsupported !== e_unsup) begin
            mismatched++;
            $display("FAIL %s: got v=%0b r=%08h z=%0b s=%0b u=%0b, expected v=%0b r=%08h z=%0b s=%0b u=%0b",
                     tag, out_valid, result, flag_zero, flag_sign, unsupported,
                     e_valid, e_result, e_zf, e_sf, e_unsup);
        end
    endtask

    // model the next edge from the present inputs, then step and compare
    task automatic tick(input string tag);
        logic [32:0] ea, eb;
        longint      prod;
        logic [31:0] sum, bv, fin;
        int          sh;
        bit          sg;
        e_valid = in_valid;
        if (in_valid) begin
            ea = ref_ext(src_a, a_half_mode, a_kind, a_byte_idx, a_signed);
            if (b_is_reg) eb = ref_ext(src_b, b_half_mode, b_kind, b_byte_idx, b_signed);
            else if (b_signed) eb = {1'b0, {{16{imm_b[15]}}, imm_b}};
            else eb = {1'b0, 16'd0, imm_b};
            bv   = eb[31:0];
            prod = longint'(ea[31:0]) * longint'(bv);
            sum  = prod[31:0] + src_c;
            sg   = a_signed || b_signed;
            sh   = (shift_sel == 2'd1) ? 7 : (shift_sel == 2'd2) ? 15 : 0;
            fin  = sg ? 32'($signed(sum) >>> sh) : (sum >> sh);
            e_result = fin;
            e_unsup  = ea[32] | (b_is_reg & eb[32]);
            if (cc_en) begin
                e_zf = (fin == 0);
                e_sf = fin[31];
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_a(logic [31:0] w, logic half, logic [1:0] k, logic [1:0] idx, logic sgn);
        src_a = w; a_half_mode = half; a_kind = k; a_byte_idx = idx; a_signed = sgn;
    endtask

    task automatic set_b(logic reg_src, logic [31:0] w, logic [15:0] imm, logic half,
                         logic [1:0] k, logic [1:0] idx, logic sgn);
        b_is_reg = reg_src; src_b = w; imm_b = imm; b_half_mode = half;
        b_kind = k; b_byte_idx = idx; b_signed = sgn;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; src_c = '0; shift_sel = '0; cc_en = 1'b0;
        set_a(32'h0, 0, 0, 0, 0);
        set_b(0, 32'h0, 16'h0, 0, 0, 0, 0);
        e_valid = 0; e_result = 0; e_zf = 0; e_sf = 0; e_unsup = 0;
        // drive the inputs with garbage during reset to show they are ignored
        in_valid = 1'b1; src_a = 32'hDEAD_BEEF; imm_b = 16'h1234; cc_en = 1'b1;
        repeat (3) @(negedge clk);
        compare("R10 reset");
        in_valid = 1'b0; cc_en = 1'b0; rst_n = 1'b1;
        tick("R10 idle after reset");

        // R1: each byte lane of A, B immediate 3 unsigned
        in_valid = 1'b1; cc_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            set_a(32'h4433_2211, 0, 0, 2'(i), 0);
            set_b(0, 32'h0, 16'd3, 0, 0, 0, 0);
            src_c = 32'd5;
            tick("R1 byte lane");
        end
        // R1: each byte lane of B from register
        for (int i = 0; i < 4; i++) begin
            set_a(32'h0000_0002, 0, 0, 0, 0);
            set_b(1, 32'hD4C3_B2A1, 16'h0, 0, 0, 2'(i), 0);
            src_c = 32'h100;
            tick("R1 byte lane B");
        end
        // R5: high-bit byte signed vs unsigned
        set_a(32'h0000_8000, 0, 0, 1, 1); set_b(0, 0, 16'd1, 0, 0, 0, 0); src_c = 0;
        tick("R5 signed byte");
        set_a(32'h0000_8000, 0, 0, 1, 0);
        tick("R5 unsigned byte");
        // R2 / R5: halves
        set_a(32'h8001_7FFE, 1, 0, 0, 0); set_b(1, 32'h0002_0003, 0, 1, 1, 0, 0);
        tick("R2 low half x high half");
        set_a(32'h8001_7FFE, 1, 1, 0, 1); set_b(1, 32'h0002_0003, 0, 1, 0, 0, 0);
        tick("R2 R5 signed high half");
        // R4: immediate sign handling, B kind ignored
        set_a(32'h0000_0003, 0, 0, 0, 0); set_b(0, 32'h0, 16'hFFFE, 1, 3, 0, 1);
        tick("R4 signed immediate");
        set_b(0, 32'h0, 16'hFFFE, 1, 2, 0, 0);
        tick("R4 unsigned immediate");
        // R6: wrap
        set_a(32'hFFFF_0000, 1, 1, 0, 0); set_b(1, 32'h0000_FFFF, 0, 1, 0, 0, 0);
        src_c = 32'hFFFF_FFFF;
        tick("R6 wrap");
        // R7: all shift codes, signed and unsigned negative sums
        for (int s = 0; s < 4; s++) begin
            shift_sel = 2'(s);
            set_a(32'h0000_00F0, 0, 0, 0, 1); set_b(0, 0, 16'd300, 0, 0, 0, 0);
            src_c = 32'h0000_1234;
            tick("R7 signed shift");
            set_a(32'h0000_00F0, 0, 0, 0, 0); src_c = 32'hF000_0000;
            tick("R7 unsigned shift");
            set_a(32'h0000_00F0, 0, 0, 0, 0); set_b(0, 0, 16'hFFFF, 0, 0, 0, 1);
            tick("R7 signed via B only");
        end
        shift_sel = 0;
        // R8: zero result, flags gated
        set_a(32'h0, 0, 0, 0, 0); set_b(0, 0, 16'd9, 0, 0, 0, 0); src_c = 0; cc_en = 1;
        tick("R8 zero flag");
        src_c = 32'h8000_0000; cc_en = 0;
        tick("R8 flags hold without cc");
        cc_en = 1;
        tick("R8 sign flag");
        // R3: unsupported kinds
        set_a(32'h1234_5678, 1, 2, 0, 0); src_c = 32'd7;
        tick("R3 full kind on A");
        set_a(32'h1234_5678, 1, 0, 0, 0); set_b(1, 32'h5, 0, 1, 3, 0, 0);
        tick("R3 reserved kind on B");
        set_b(1, 32'h5, 0, 1, 0, 0, 0);
        tick("R3 clears");
        // R9: idle cycles hold
        in_valid = 0; src_a = 32'hFFFF_FFFF; src_c = 32'h1;
        tick("R9 idle hold");
        tick("R9 idle hold 2");
        in_valid = 1;
        tick("R9 resume");
        // randomized mix
        for (int n = 0; n < 400; n++) begin
            in_valid = ($urandom_range(0, 7) != 0);
            set_a($urandom, 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
            set_b(1'($urandom), $urandom, 16'($urandom), 1'($urandom), 2'($urandom),
                  2'($urandom), 1'($urandom));
            src_c = $urandom; shift_sel = 2'($urandom); cc_en = 1'($urandom);
            tick("R6 random mix");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule